// File: doc/BRIEF.md
# VGA Memory-Mapped Register Window Bridge

This block sits behind one memory-mapped window of a display controller and turns simple bus requests into the accesses that three register targets expect. The window holds three sub-windows. The legacy sub-window forwards byte accesses to an 8-bit legacy I/O register port. It splits 16-bit writes into two ordered byte writes and merges 16-bit reads from two byte reads. The extension sub-window turns a flat byte offset into a register index. It writes that index to an indexed 16-bit register file, then performs the data access. The extended-control sub-window is served locally. It holds a read-only bank length register and a framebuffer byte-order register, which keeps its state in a flag that is driven out of the block.

A requester holds `req_valid` with its address, size, direction and data until `req_ready` pulses for one cycle. Read data is valid in that cycle. The legacy port and the extension register file are external. Both must return read data combinationally in the cycle their enable is high.

Top module: `vga_mmio_bridge`

## Requirements
- R1: A 1-byte access at offset A of the legacy sub-window (bus addresses 0x400 to 0x4FF) makes exactly one port access at port 0x3C0+A. A write carries byte 7:0 of the write data. A read returns the port byte in bits 7:0 and zero above. `req_ready` is high 2 cycles after the accepting edge.
- R2: A 2-byte legacy write makes two consecutive port writes: the low byte to port 0x3C0+A, then the high byte to port 0x3C1+A. `req_ready` stays low until the second write is done and rises 3 cycles after the accepting edge.
- R3: A 2-byte legacy read returns the byte of port 0x3C0+A in bits 7:0 and the byte of port 0x3C1+A in bits 15:8, with zero above.
- R4: A legacy access whose size is not 1 or 2 bytes makes no port access. It reads as zero and completes 1 cycle after the accepting edge.
- R5: An access at offset B of the extension sub-window (0x500 to 0x5FF) first writes index B>>1 (`ext_sel_idx`=1), then reads or writes the 16-bit data register (`ext_sel_idx`=0). Reads return the data in bits 15:0, and `req_ready` rises 3 cycles after the accepting edge.
- R6: The extended-control sub-window (0x600 to 0x6FF) acts only on 4-byte accesses. At any other size it reads zero and ignores writes.
- R7: Offset 0x00 of the extended-control bank reads 0x100, the bank length. Offset 0x04 reads 0xBEBEBEBE while `be_flag` is 1 and 0x1E1E1E1E while it is 0.
- R8: A write to offset 0x04 sets `be_flag` only for the value 0xBEBEBEBE and clears it only for 0x1E1E1E1E. Any other value leaves it unchanged.
- R9: All other offsets in the extended-control bank read zero and ignore writes, including the value 0xBEBEBEBE.
- R10: After reset, `be_flag` is 0, `req_ready` is low, and neither port enable is active.
- R11: An address outside all three sub-windows makes no port access. It reads zero and completes 1 cycle after the accepting edge, as do all extended-control accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, little-endian lanes |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read data, valid with req_ready |
| leg_en | output | 1 | Legacy port access strobe |
| leg_we | output | 1 | Legacy port write |
| leg_port | output | 16 | Legacy I/O port number |
| leg_wdata | output | 8 | Legacy write byte |
| leg_rdata | input | 8 | Legacy read byte, same cycle |
| ext_en | output | 1 | Extension register file strobe |
| ext_sel_idx | output | 1 | 1 = index register, 0 = data register |
| ext_we | output | 1 | Extension write |
| ext_wdata | output | 16 | Extension index or write data |
| ext_rdata | input | 16 | Extension read data, same cycle |
| be_flag | output | 1 | Framebuffer big-endian flag |

## Verification
A wrong sequencer state shows up at once on the port strobes and on the completion pulse. A missing or extra byte cycle, or swapped byte order, is a port event out of order on the very clock it happens. A shifted `req_ready` also appears in that cycle. A byte-order flag corrupted by a rejected code shows on `be_flag` the cycle after the write. It shows again at the next read of offset 0x04, so the bench compares the flag after every access. A merge lane error or an index off by one stays hidden until the affected register is read back. The bench therefore reads back every location it writes, through the same window and at both access sizes.

// File: rtl/vga_bridge_pkg.sv
package vga_bridge_pkg;
   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_LEG  = 2'd1,
      WIN_EXT  = 2'd2,
      WIN_CTL  = 2'd3
   } win_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_LLO  = 3'd1,
      ST_LHI  = 3'd2,
      ST_XIDX = 3'd3,
      ST_XDAT = 3'd4,
      ST_RESP = 3'd5
   } seq_st_e;
endpackage

// File: rtl/vga_win_decode.sv
module vga_win_decode
   import vga_bridge_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned OFF_W    = 8,
   parameter int unsigned LEG_BASE = 'h400,
   parameter int unsigned EXT_BASE = 'h500,
   parameter int unsigned CTL_BASE = 'h600
) (
   input  logic [ADDR_W-1:0] addr,
   output win_e              win,
   output logic [OFF_W-1:0]  off
);
   localparam int unsigned NWIN = 3;

   logic [NWIN-1:0] hit;

   for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
      localparam logic [ADDR_W-1:0] BASE =
         (gi == 0) ? ADDR_W'(LEG_BASE) :
         (gi == 1) ? ADDR_W'(EXT_BASE) : ADDR_W'(CTL_BASE);
      if (BASE[OFF_W-1:0] != '0) begin : g_misaligned
         $error("sub-window base not aligned to window size");
      end
      assign hit[gi] = (addr[ADDR_W-1:OFF_W] == BASE[ADDR_W-1:OFF_W]);
   end

   always_comb begin
      if (hit[0])      win = WIN_LEG;
      else if (hit[1]) win = WIN_EXT;
      else if (hit[2]) win = WIN_CTL;
      else             win = WIN_NONE;
   end

   assign off = addr[OFF_W-1:0];
endmodule

// File: rtl/vga_ctl_bank.sv
module vga_ctl_bank #(
   parameter int unsigned OFF_W    = 8,
   parameter int unsigned BANK_LEN = 256,
   parameter int unsigned SZ_OFF   = 0,
   parameter int unsigned BO_OFF   = 4,
   parameter logic [31:0] BE_CODE  = 32'hBEBE_BEBE,
   parameter logic [31:0] LE_CODE  = 32'h1E1E_1E1E
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             acc,
   input  logic             we,
   input  logic [2:0]       size,
   input  logic [OFF_W-1:0] off,
   input  logic [31:0]      wdata,
   output logic [31:0]      rdata,
   output logic             be_flag
);
   localparam logic [OFF_W-1:0] SZ_O = OFF_W'(SZ_OFF);
   localparam logic [OFF_W-1:0] BO_O = OFF_W'(BO_OFF);

   if (BE_CODE == LE_CODE) begin : g_same_codes
      $error("byte-order codes must differ");
   end
   if (SZ_OFF == BO_OFF) begin : g_same_offs
      $error("control register offsets must differ");
   end

   logic full_word;
   logic wr_hit;

   assign full_word = (size == 3'd4);
   assign wr_hit    = acc && we && full_word && (off == BO_O);

   always_ff @(posedge clk) begin
      if (rst) begin
         be_flag <= 1'b0;
      end else if (wr_hit) begin
         if (wdata == BE_CODE)      be_flag <= 1'b1;
         else if (wdata == LE_CODE) be_flag <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (full_word) begin
         if (off == SZ_O)      rdata = 32'(BANK_LEN);
         else if (off == BO_O) rdata = be_flag ? BE_CODE : LE_CODE;
      end
   end

   // R8: the flag moves only after a full-word write of a recognised code
   assert_flag_codes_R8: assert property (@(posedge clk) disable iff (rst)
      !$stable(be_flag) |-> ($past(wr_hit) &&
         (be_flag ? ($past(wdata) == BE_CODE) : ($past(wdata) == LE_CODE))));
endmodule

// File: rtl/vga_bridge_seq.sv
module vga_bridge_seq
   import vga_bridge_pkg::*;
#(
   parameter int unsigned OFF_W    = 8,
   parameter logic [15:0] LEG_PORT = 16'h03C0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [2:0]       req_size,
   input  logic [31:0]      req_wdata,
   input  win_e             dec_win,
   input  logic [OFF_W-1:0] dec_off,
   input  logic [31:0]      ctl_rdata,
   output logic             ctl_acc,
   output logic             req_ready,
   output logic [31:0]      req_rdata,
   output logic             leg_en,
   output logic             leg_we,
   output logic [15:0]      leg_port,
   output logic [7:0]       leg_wdata,
   input  logic [7:0]       leg_rdata,
   output logic             ext_en,
   output logic             ext_sel_idx,
   output logic             ext_we,
   output logic [15:0]      ext_wdata,
   input  logic [15:0]      ext_rdata
);
   if (OFF_W > 16) begin : g_wide_off
      $error("offset wider than the port number");
   end

   seq_st_e          st, st_nxt;
   logic             accept;
   logic             r_we;
   logic             r_two;
   logic [OFF_W-1:0] r_off;
   logic [31:0]      r_wdata;
   logic [31:0]      r_rdata;
   logic             leg_size_ok;

   assign accept      = (st == ST_IDLE) && req_valid;
   assign ctl_acc     = accept && (dec_win == WIN_CTL);
   assign leg_size_ok = (req_size == 3'd1) || (req_size == 3'd2);

   always_comb begin
      st_nxt = st;
      unique case (st)
         ST_IDLE: begin
            if (req_valid) begin
               unique case (dec_win)
                  WIN_LEG: st_nxt = leg_size_ok ? ST_LLO : ST_RESP;
                  WIN_EXT: st_nxt = ST_XIDX;
                  default: st_nxt = ST_RESP;
               endcase
            end
         end
         ST_LLO:  st_nxt = r_two ? ST_LHI : ST_RESP;
         ST_LHI:  st_nxt = ST_RESP;
         ST_XIDX: st_nxt = ST_XDAT;
         ST_XDAT: st_nxt = ST_RESP;
         ST_RESP: st_nxt = ST_IDLE;
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st      <= ST_IDLE;
         r_we    <= 1'b0;
         r_two   <= 1'b0;
         r_off   <= '0;
         r_wdata <= '0;
         r_rdata <= '0;
      end else begin
         st <= st_nxt;
         if (accept) begin
            r_we    <= req_write;
            r_two   <= (req_size == 3'd2);
            r_off   <= dec_off;
            r_wdata <= req_wdata;
            r_rdata <= (dec_win == WIN_CTL && !req_write) ? ctl_rdata : '0;
         end else if (!r_we) begin
            if (st == ST_LLO)  r_rdata[7:0]  <= leg_rdata;
            if (st == ST_LHI)  r_rdata[15:8] <= leg_rdata;
            if (st == ST_XDAT) r_rdata       <= {16'h0000, ext_rdata};
         end
      end
   end

   assign leg_en      = (st == ST_LLO) || (st == ST_LHI);
   assign leg_we      = r_we;
   assign leg_port    = LEG_PORT + 16'(r_off) + {15'd0, (st == ST_LHI)};
   assign leg_wdata   = (st == ST_LHI) ? r_wdata[15:8] : r_wdata[7:0];

   assign ext_en      = (st == ST_XIDX) || (st == ST_XDAT);
   assign ext_sel_idx = (st == ST_XIDX);
   assign ext_we      = (st == ST_XIDX) || r_we;
   assign ext_wdata   = (st == ST_XIDX) ? 16'(r_off >> 1) : r_wdata[15:0];

   assign req_ready   = (st == ST_RESP);
   assign req_rdata   = req_ready ? r_rdata : '0;

   // R2: back-to-back port cycles are the high byte following the low byte
   assert_word_order_R2: assert property (@(posedge clk) disable iff (rst)
      (leg_en && $past(leg_en)) |->
         ((leg_port == $past(leg_port) + 16'd1) && (leg_we == $past(leg_we))));

   // R5: a data-register access is always preceded by the index write
   assert_index_first_R5: assert property (@(posedge clk) disable iff (rst)
      (ext_en && !ext_sel_idx) |-> $past(ext_en && ext_sel_idx && ext_we));

   // R11: completion is a single-cycle pulse
   assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (rst)
      req_ready |=> !req_ready);

   // R10: no target is strobed while the completion pulse is up
   assert_quiet_on_ready_R10: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (!leg_en && !ext_en));
endmodule

// File: rtl/vga_mmio_bridge.sv
module vga_mmio_bridge
   import vga_bridge_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned WIN_SIZE = 256,
   parameter int unsigned LEG_BASE = 'h400,
   parameter int unsigned EXT_BASE = 'h500,
   parameter int unsigned CTL_BASE = 'h600,
   parameter logic [15:0] LEG_PORT = 16'h03C0,
   parameter int unsigned SZ_OFF   = 0,
   parameter int unsigned BO_OFF   = 4,
   parameter logic [31:0] BE_CODE  = 32'hBEBE_BEBE,
   parameter logic [31:0] LE_CODE  = 32'h1E1E_1E1E,
   parameter bit          CTL_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_size,
   input  logic [31:0]       req_wdata,
   output logic              req_ready,
   output logic [31:0]       req_rdata,
   output logic              leg_en,
   output logic              leg_we,
   output logic [15:0]       leg_port,
   output logic [7:0]        leg_wdata,
   input  logic [7:0]        leg_rdata,
   output logic              ext_en,
   output logic              ext_sel_idx,
   output logic              ext_we,
   output logic [15:0]       ext_wdata,
   input  logic [15:0]       ext_rdata,
   output logic              be_flag
);
   localparam int unsigned OFF_W = $clog2(WIN_SIZE);

   if ((WIN_SIZE & (WIN_SIZE - 1)) != 0 || WIN_SIZE < 8) begin : g_bad_win
      $error("window size must be a power of two of at least 8");
   end
   if (OFF_W >= ADDR_W) begin : g_bad_addr
      $error("address too narrow for the sub-windows");
   end
   if (LEG_BASE == EXT_BASE || LEG_BASE == CTL_BASE || EXT_BASE == CTL_BASE) begin : g_overlap
      $error("sub-windows must not overlap");
   end
   if (SZ_OFF >= WIN_SIZE || BO_OFF >= WIN_SIZE) begin : g_bad_regs
      $error("control register offsets outside the bank");
   end

   win_e             dec_win;
   logic [OFF_W-1:0] dec_off;
   logic [31:0]      ctl_rdata;
   logic             ctl_acc;

   vga_win_decode #(
      .ADDR_W  (ADDR_W),
      .OFF_W   (OFF_W),
      .LEG_BASE(LEG_BASE),
      .EXT_BASE(EXT_BASE),
      .CTL_BASE(CTL_BASE)
   ) u_decode (
      .addr(req_addr),
      .win (dec_win),
      .off (dec_off)
   );

   if (CTL_EN) begin : g_ctl
      vga_ctl_bank #(
         .OFF_W   (OFF_W),
         .BANK_LEN(WIN_SIZE),
         .SZ_OFF  (SZ_OFF),
         .BO_OFF  (BO_OFF),
         .BE_CODE (BE_CODE),
         .LE_CODE (LE_CODE)
      ) u_ctl (
         .clk    (clk),
         .rst    (rst),
         .acc    (ctl_acc),
         .we     (req_write),
         .size   (req_size),
         .off    (dec_off),
         .wdata  (req_wdata),
         .rdata  (ctl_rdata),
         .be_flag(be_flag)
      );
   end else begin : g_no_ctl
      assign ctl_rdata = '0;
      assign be_flag   = 1'b0;
   end

   vga_bridge_seq #(
      .OFF_W   (OFF_W),
      .LEG_PORT(LEG_PORT)
   ) u_seq (
      .clk        (clk),
      .rst        (rst),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_size   (req_size),
      .req_wdata  (req_wdata),
      .dec_win    (dec_win),
      .dec_off    (dec_off),
      .ctl_rdata  (ctl_rdata),
      .ctl_acc    (ctl_acc),
      .req_ready  (req_ready),
      .req_rdata  (req_rdata),
      .leg_en     (leg_en),
      .leg_we     (leg_we),
      .leg_port   (leg_port),
      .leg_wdata  (leg_wdata),
      .leg_rdata  (leg_rdata),
      .ext_en     (ext_en),
      .ext_sel_idx(ext_sel_idx),
      .ext_we     (ext_we),
      .ext_wdata  (ext_wdata),
      .ext_rdata  (ext_rdata)
   );
endmodule

// File: tb/vga_mmio_bridge_tb_top.sv
module vga_mmio_bridge_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [11:0] req_addr  = '0;
   logic [2:0]  req_size  = 3'd1;
   logic [31:0] req_wdata = '0;
   logic        req_ready;
   logic [31:0] req_rdata;
   logic        leg_en, leg_we;
   logic [15:0] leg_port;
   logic [7:0]  leg_wdata, leg_rdata;
   logic        ext_en, ext_sel_idx, ext_we;
   logic [15:0] ext_wdata, ext_rdata;
   logic        be_flag;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   vga_mmio_bridge dut_i (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_size(req_size), .req_wdata(req_wdata),
      .req_ready(req_ready), .req_rdata(req_rdata),
      .leg_en(leg_en), .leg_we(leg_we), .leg_port(leg_port),
      .leg_wdata(leg_wdata), .leg_rdata(leg_rdata),
      .ext_en(ext_en), .ext_sel_idx(ext_sel_idx), .ext_we(ext_we),
      .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
      .be_flag(be_flag)
   );

   // ---------------- target stubs ----------------
   logic [7:0]  leg_mem [0:257];
   logic [15:0] ext_regs [0:127];
   logic [6:0]  ext_ix;
   int          leg_pi;

   assign leg_pi    = int'(leg_port) - 'h3C0;
   assign leg_rdata = (leg_pi >= 0 && leg_pi < 258) ? leg_mem[leg_pi] : 8'h00;
   assign ext_rdata = ext_regs[ext_ix];

   always @(posedge clk) begin
      if (leg_en && leg_we && leg_pi >= 0 && leg_pi < 258) leg_mem[leg_pi] <= leg_wdata;
      if (ext_en && ext_we) begin
         if (ext_sel_idx) ext_ix <= ext_wdata[6:0];
         else             ext_regs[ext_ix] <= ext_wdata;
      end
   end

   // ---------------- reference model state ----------------
   logic [7:0]  sh_leg [0:257];
   logic [15:0] sh_ext [0:127];
   bit          sh_flag = 1'b0;
   int q_kind[$];
   int q_port[$];
   int q_we[$];
   int q_data[$];

   initial begin
      ext_ix = '0;
      for (int i = 0; i < 258; i++) begin
         leg_mem[i] = 8'(i ^ 'h5A);
         sh_leg[i]  = 8'(i ^ 'h5A);
      end
      for (int i = 0; i < 128; i++) begin
         ext_regs[i] = 16'('h1000 + i * 3);
         sh_ext[i]   = 16'('h1000 + i * 3);
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic push_ev(input int kind, input int port, input int we, input int data);
      q_kind.push_back(kind);
      q_port.push_back(port);
      q_we.push_back(we);
      q_data.push_back(data);
   endtask

   // kind 0 = legacy byte, 1 = extension index, 2 = extension data
   always @(negedge clk) begin
      if (!rst && (leg_en || ext_en)) begin
         int k, p, w, d;
         k = leg_en ? 0 : (ext_sel_idx ? 1 : 2);
         p = leg_en ? int'(leg_port) : 0;
         w = leg_en ? int'(leg_we) : int'(ext_we);
         d = leg_en ? int'(leg_wdata) : int'(ext_wdata);
         if (leg_en && ext_en) chk(1'b0, "R5", "both targets strobed", 32'd1, 32'd0);
         if (q_kind.size() == 0) begin
            chk(1'b0, "R4", "unexpected port event", 32'(k), 32'hFFFF_FFFF);
         end else begin
            chk(q_kind[0] == k, "R2", "event kind", 32'(k), 32'(q_kind[0]));
            if (k == 0) chk(q_port[0] == p, "R1", "port number", 32'(p), 32'(q_port[0]));
            chk(q_we[0] == w, "R5", "event direction", 32'(w), 32'(q_we[0]));
            if (w != 0) chk(q_data[0] == d, "R2", "event data", 32'(d), 32'(q_data[0]));
            void'(q_kind.pop_front());
            void'(q_port.pop_front());
            void'(q_we.pop_front());
            void'(q_data.pop_front());
         end
      end
   end

   task automatic model(input bit we, input int addr, input int size,
                        input logic [31:0] wd, output logic [31:0] exp, output int lat);
      exp = '0;
      lat = 1;
      if (addr >= 'h400 && addr < 'h500) begin
         int a;
         a = addr - 'h400;
         if (size == 1) begin
            lat = 2;
            push_ev(0, 'h3C0 + a, we, int'(wd[7:0]));
            if (we) sh_leg[a] = wd[7:0];
            else    exp = {24'h0, sh_leg[a]};
         end else if (size == 2) begin
            lat = 3;
            push_ev(0, 'h3C0 + a, we, int'(wd[7:0]));
            push_ev(0, 'h3C1 + a, we, int'(wd[15:8]));
            if (we) begin
               sh_leg[a]     = wd[7:0];
               sh_leg[a + 1] = wd[15:8];
            end else begin
               exp = {16'h0, sh_leg[a + 1], sh_leg[a]};
            end
         end
      end else if (addr >= 'h500 && addr < 'h600) begin
         int ix;
         ix  = (addr - 'h500) >> 1;
         lat = 3;
         push_ev(1, 0, 1, ix);
         push_ev(2, 0, we, int'(wd[15:0]));
         if (we) sh_ext[ix] = wd[15:0];
         else    exp = {16'h0, sh_ext[ix]};
      end else if (addr >= 'h600 && addr < 'h700) begin
         if (size == 4) begin
            int o;
            o = addr - 'h600;
            if (we) begin
               if (o == 4 && wd == 32'hBEBE_BEBE) sh_flag = 1'b1;
               if (o == 4 && wd == 32'h1E1E_1E1E) sh_flag = 1'b0;
            end else if (o == 0) begin
               exp = 32'h100;
            end else if (o == 4) begin
               exp = sh_flag ? 32'hBEBE_BEBE : 32'h1E1E_1E1E;
            end
         end
      end
   endtask

   task automatic acc(input bit we, input int addr, input int size,
                      input logic [31:0] wd, input string tag);
      logic [31:0] exp;
      int lat;
      bit got;
      model(we, addr, size, wd, exp, lat);
      req_valid = 1'b1;
      req_write = we;
      req_addr  = addr[11:0];
      req_size  = size[2:0];
      req_wdata = wd;
      got = 1'b0;
      for (int c = 1; c <= lat + 2 && !got; c++) begin
         @(negedge clk);
         chk(req_ready === (c == lat), tag, "ready timing", {31'd0, req_ready},
             {31'd0, (c == lat)});
         if (req_ready === 1'b1) begin
            got = 1'b1;
            chk(req_rdata === exp, tag, "read data", req_rdata, exp);
            req_valid = 1'b0;
         end
      end
      if (!got) begin
         req_valid = 1'b0;
         chk(1'b0, tag, "no completion", 32'd0, 32'd1);
      end
      @(negedge clk);
      chk(q_kind.size() == 0, tag, "missing port events", 32'(q_kind.size()), 32'd0);
      chk(be_flag === sh_flag, tag, "byte-order flag", {31'd0, be_flag}, {31'd0, sh_flag});
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(req_ready === 1'b0, "R10", "ready in reset", {31'd0, req_ready}, 32'd0);
      chk(leg_en === 1'b0 && ext_en === 1'b0, "R10", "strobes in reset",
          {30'd0, leg_en, ext_en}, 32'd0);
      chk(be_flag === 1'b0, "R10", "flag in reset", {31'd0, be_flag}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      chk(be_flag === 1'b0 && req_ready === 1'b0, "R10", "after reset",
          {30'd0, be_flag, req_ready}, 32'd0);

      // R1: byte accesses
      acc(1'b0, 'h404, 1, 32'h0, "R1");
      acc(1'b1, 'h404, 1, 32'hFFFF_FF11, "R1");
      acc(1'b0, 'h404, 1, 32'h0, "R1");
      acc(1'b0, 'h4FF, 1, 32'h0, "R1");
      // R2 / R3: word split and merge
      acc(1'b1, 'h404, 2, 32'h0000_A755, "R2");
      acc(1'b0, 'h404, 2, 32'h0, "R3");
      acc(1'b0, 'h405, 1, 32'h0, "R2");
      acc(1'b1, 'h4FF, 2, 32'h0000_C3B2, "R2");
      acc(1'b0, 'h4FF, 2, 32'h0, "R3");
      acc(1'b0, 'h420, 2, 32'h0, "R3");
      // R4: other legacy sizes
      acc(1'b1, 'h410, 4, 32'hDEAD_BEEF, "R4");
      acc(1'b1, 'h410, 3, 32'hDEAD_BEEF, "R4");
      acc(1'b0, 'h410, 4, 32'h0, "R4");
      acc(1'b0, 'h410, 2, 32'h0, "R4");
      // R5: extension index then data
      acc(1'b1, 'h50A, 2, 32'h0000_1234, "R5");
      acc(1'b0, 'h50A, 2, 32'h0, "R5");
      acc(1'b0, 'h50B, 1, 32'h0, "R5");
      acc(1'b1, 'h5FE, 4, 32'h7777_9ABC, "R5");
      acc(1'b0, 'h5FF, 2, 32'h0, "R5");
      acc(1'b0, 'h500, 2, 32'h0, "R5");
      // R7 / R8: control bank
      acc(1'b0, 'h600, 4, 32'h0, "R7");
      acc(1'b0, 'h604, 4, 32'h0, "R7");
      acc(1'b1, 'h604, 4, 32'hBEBE_BEBE, "R8");
      acc(1'b0, 'h604, 4, 32'h0, "R7");
      acc(1'b1, 'h604, 4, 32'h1234_5678, "R8");
      acc(1'b1, 'h604, 4, 32'hBEBE_BEBF, "R8");
      acc(1'b0, 'h604, 4, 32'h0, "R8");
      acc(1'b1, 'h604, 4, 32'h1E1E_1E1E, "R8");
      acc(1'b0, 'h604, 4, 32'h0, "R8");
      // R6: wrong sizes in the control bank
      acc(1'b1, 'h604, 2, 32'hBEBE_BEBE, "R6");
      acc(1'b1, 'h604, 1, 32'hBEBE_BEBE, "R6");
      acc(1'b0, 'h600, 2, 32'h0, "R6");
      acc(1'b0, 'h604, 1, 32'h0, "R6");
      // R9: other control offsets
      acc(1'b1, 'h608, 4, 32'hBEBE_BEBE, "R9");
      acc(1'b0, 'h608, 4, 32'h0, "R9");
      acc(1'b0, 'h6FC, 4, 32'h0, "R9");
      acc(1'b1, 'h604, 4, 32'hBEBE_BEBE, "R8");
      acc(1'b1, 'h600, 4, 32'h1E1E_1E1E, "R9");
      acc(1'b0, 'h604, 4, 32'h0, "R9");
      // R11: outside every sub-window
      acc(1'b0, 'h100, 4, 32'h0, "R11");
      acc(1'b1, 'h7FF, 1, 32'h0000_00AA, "R11");
      acc(1'b0, 'h3FF, 2, 32'h0, "R11");
      acc(1'b0, 'h000, 1, 32'h0, "R11");
      // legacy contents still intact after the ignored accesses
      acc(1'b0, 'h4FF, 2, 32'h0, "R11");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule